// File: doc/BRIEF.md
# Configuration Bitstream Frame Checker

This block watches a serial configuration stream that arrives one bit per valid strobe. It can also take one byte at a time, which it turns into bits in a fixed order. It locks onto the header only after it sees a run of fill ones followed by a four-bit preamble. It then captures a 24-bit length count and checks a separator. After that it walks a fixed number of fixed-length data frames.

Each frame has a start bit, a payload and a four-bit check field. The check field is either a fixed constant or the low bits of a running CRC. When a frame's check passes, the block presents the payload on a parallel output and pulses a strobe.

After the last frame the block expects a postamble. It then takes a few don't-care start-up bits and signals completion. Any field mismatch, or any stream longer than its own length count, pulls an active-low error output low. The error stays until a program pulse or a reset.

Top module: `cfg_stream_checker`

## Requirements
- R1: After reset, or one cycle after a `program_i` pulse, `init_n_o` is 1, `cfg_done_o` is 0, `frame_done_o` is 0, the CRC register is zero and the parser is hunting for fill.
- R2: While hunting, a run of at least 8 ones followed by the bits 0,0,1,0 in stream order locks the header. A 0 that arrives before 8 ones have been seen restarts the count, so it cannot lock.
- R3: The 24 bits after the preamble form the length count, most significant bit first, and `length_o` shows it from then on.
- R4: The four bits after the length count must all be 1. Any 0 there is an error.
- R5: Each frame starts with one bit that must be 0. A 1 there is an error.
- R6: When `crc_mode_i` is 0, each frame's check field, read first bit to last, must equal 0,1,1,0.
- R7: When `crc_mode_i` is 1, the check field, first bit as bit 3, must equal bits 3..0 of a CRC-16 register. The register uses polynomial x^16+x^15+x^2+1, shifts MSB first, starts at zero, covers each frame's start and payload bits, and is never cleared between frames.
- R8: The first payload bit of a frame lands in bit 0 of `frame_data_o`. `frame_done_o` goes high for exactly one cycle, right after the edge that accepts the last bit of a correct check field.
- R9: After `NUM_FRAMES` frames the stream must carry 0,1,1,1,1,1,1,1. Any mismatch is an error, and this includes a surplus frame.
- R10: `cfg_done_o` rises only after 4 further bits of any value have been accepted after the postamble. It stays high until program or reset.
- R11: Bits are counted from the first separator bit through the last postamble bit. Once that count exceeds the length count, the block flags an error.
- R12: After an error, `init_n_o` stays 0 and further bits have no effect: no frame strobe and no done. This holds until `program_i` or reset.
- R13: When `byte_mode_i` is 1, a byte loaded with `byte_valid_i` is fed to the parser over the next 8 cycles, D0 first. The next byte may be loaded in the cycle that feeds the previous byte's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| program_i | input | 1 | Synchronous restart of parsing, error clear, CRC clear |
| crc_mode_i | input | 1 | 1: CRC check fields, 0: constant check fields |
| byte_mode_i | input | 1 | 1: take data from the byte input, 0: from the bit input |
| bit_valid_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial data bit |
| byte_valid_i | input | 1 | Byte load strobe |
| byte_i | input | 8 | Parallel byte, D0 sent first |
| frame_data_o | output | FRAME_BITS | Payload of the last frame that passed its check |
| frame_done_o | output | 1 | One-cycle frame-complete strobe |
| length_o | output | 24 | Captured length count |
| init_n_o | output | 1 | Low while in error |
| cfg_done_o | output | 1 | High once start-up bits are taken |

## Verification
Two events can fall on the same accepted bit: a per-field check on the last postamble bit, and the length-overrun test. A stream whose length count is one less than the true count forces both onto that bit. The bench expects the overrun to win, so the block must end in error with `cfg_done_o` low even though every field was correct. A second case sends exactly the right count and must finish cleanly. The difference between the two cases shows that the comparison boundary sits at "greater than" and not at "equal to".

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;

  typedef enum logic [3:0] {
    ST_HUNT, ST_PRE, ST_LEN, ST_SEP, ST_START, ST_DATA,
    ST_CHK, ST_POST, ST_STUP, ST_DONE, ST_ERR
  } pstate_e;

  localparam int          FILL_MIN    = 8;
  localparam int          LEN_BITS    = 24;
  localparam int          SEP_BITS    = 4;
  localparam int          STARTUP_MIN = 4;
  localparam logic [3:0]  PREAMBLE    = 4'b0010;   // stream order, MSB first
  localparam logic [7:0]  POSTAMBLE   = 8'b01111111;
  localparam logic [3:0]  CONST_CHK   = 4'b0110;
  localparam logic [15:0] CRC_POLY    = 16'h8005;

  // one serial CRC-16 step, MSB-first shift
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  function automatic logic pre_bit(input int idx);
    return PREAMBLE[3 - idx];
  endfunction

  function automatic logic post_bit(input int idx);
    return POSTAMBLE[7 - idx];
  endfunction

endpackage

// File: rtl/cfg_byte_ser.sv
module cfg_byte_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       bit_v_o,
  output logic       bit_o
);
  logic [7:0] shreg;
  logic [3:0] cnt;

  assign bit_v_o = (cnt != 4'd0);
  assign bit_o   = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load_i) begin
      shreg <= byte_i;
      cnt   <= 4'd8;
    end else if (cnt != 4'd0) begin
      shreg <= {1'b0, shreg[7:1]};
      cnt   <= cnt - 4'd1;
    end
  end

  p_ser_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 4'd0 && !load_i) |=> (cnt == $past(cnt) - 4'd1));

  p_ser_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
  import cfg_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [3:0] chk_nib_o
);
  logic [15:0] crc_q;

  assign chk_nib_o = crc_q[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= crc16_step(crc_q, bit_i);
  end

  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(crc_q));

  p_crc_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_q == 16'h0000));

endmodule

// File: rtl/cfg_parser.sv
module cfg_parser
  import cfg_chk_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  program_i,
  input  logic                  crc_mode_i,
  input  logic                  bv_i,
  input  logic                  b_i,
  input  logic [3:0]            crc_nib_i,
  output logic                  crc_en_o,
  output logic [FRAME_BITS-1:0] frame_data_o,
  output logic                  frame_done_o,
  output logic [LEN_BITS-1:0]   length_o,
  output logic                  init_n_o,
  output logic                  cfg_done_o
);
  localparam int MAXF = (FRAME_BITS > LEN_BITS) ? FRAME_BITS : LEN_BITS;
  localparam int CW   = $clog2(MAXF + 1);
  localparam int FW   = $clog2(NUM_FRAMES + 1);

  pstate_e              state;
  logic [3:0]           ones;
  logic [CW-1:0]        fcnt;
  logic [FW-1:0]        frm;
  logic [LEN_BITS-1:0]  len_q;
  logic [LEN_BITS:0]    bcnt;
  logic [FRAME_BITS-1:0] pay;
  logic [2:0]           nib;

  // named internal events
  logic                 bit_take, counted, overrun, field_bad;
  logic [LEN_BITS:0]    bcnt_next;
  logic [3:0]           chk_val, chk_exp;

  assign bit_take  = bv_i && !program_i && state != ST_DONE && state != ST_ERR;
  assign counted   = (state == ST_SEP) || (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_CHK) || (state == ST_POST);
  assign bcnt_next = bcnt + 1'b1;
  assign overrun   = bit_take && counted && (bcnt_next > {1'b0, len_q});
  assign chk_val   = {nib, b_i};
  assign chk_exp   = crc_mode_i ? crc_nib_i : CONST_CHK;

  always_comb begin
    field_bad = 1'b0;
    case (state)
      ST_SEP:   field_bad = !b_i;
      ST_START: field_bad = b_i;
      ST_CHK:   field_bad = (fcnt == CW'(3)) && (chk_val != chk_exp);
      ST_POST:  field_bad = (b_i != post_bit(int'(fcnt)));
      default:  field_bad = 1'b0;
    endcase
  end

  assign crc_en_o     = bit_take && !overrun &&
                        (state == ST_START || state == ST_DATA);
  assign length_o     = len_q;
  assign init_n_o     = (state != ST_ERR);
  assign cfg_done_o   = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT; ones <= '0; fcnt <= '0; frm <= '0;
      len_q <= '0; bcnt <= '0; pay <= '0; nib <= '0;
      frame_data_o <= '0; frame_done_o <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      if (program_i) begin
        state <= ST_HUNT; ones <= '0; fcnt <= '0; frm <= '0;
        len_q <= '0; bcnt <= '0; nib <= '0;
      end else if (bit_take) begin
        if (counted) bcnt <= bcnt_next;
        if (overrun || (bit_take && field_bad)) begin
          state <= ST_ERR;
        end else begin
          case (state)
            ST_HUNT: begin
              if (b_i) begin
                if (ones != 4'(FILL_MIN)) ones <= ones + 4'd1;
              end else if (ones == 4'(FILL_MIN)) begin
                state <= ST_PRE; fcnt <= CW'(1);
              end else begin
                ones <= '0;
              end
            end
            ST_PRE: begin
              if (b_i != pre_bit(int'(fcnt))) begin
                state <= ST_HUNT; ones <= b_i ? 4'd1 : 4'd0;
              end else if (fcnt == CW'(3)) begin
                state <= ST_LEN; fcnt <= '0;
              end else fcnt <= fcnt + 1'b1;
            end
            ST_LEN: begin
              len_q <= {len_q[LEN_BITS-2:0], b_i};
              if (fcnt == CW'(LEN_BITS-1)) begin
                state <= ST_SEP; fcnt <= '0; bcnt <= '0;
              end else fcnt <= fcnt + 1'b1;
            end
            ST_SEP: begin
              if (fcnt == CW'(SEP_BITS-1)) begin
                state <= ST_START; fcnt <= '0; frm <= '0;
              end else fcnt <= fcnt + 1'b1;
            end
            ST_START: begin
              state <= ST_DATA; fcnt <= '0;
            end
            ST_DATA: begin
              pay <= {b_i, pay[FRAME_BITS-1:1]};
              if (fcnt == CW'(FRAME_BITS-1)) begin
                state <= ST_CHK; fcnt <= '0;
              end else fcnt <= fcnt + 1'b1;
            end
            ST_CHK: begin
              nib <= chk_val[2:0];
              if (fcnt == CW'(3)) begin
                fcnt <= '0;
                frame_data_o <= pay;
                frame_done_o <= 1'b1;
                if (frm == FW'(NUM_FRAMES-1)) state <= ST_POST;
                else begin
                  state <= ST_START; frm <= frm + 1'b1;
                end
              end else fcnt <= fcnt + 1'b1;
            end
            ST_POST: begin
              if (fcnt == CW'(7)) begin
                state <= ST_STUP; fcnt <= '0;
              end else fcnt <= fcnt + 1'b1;
            end
            ST_STUP: begin
              if (fcnt == CW'(STARTUP_MIN-1)) state <= ST_DONE;
              else fcnt <= fcnt + 1'b1;
            end
            default: state <= state;
          endcase
        end
      end
    end
  end

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n_o && !program_i) |=> !init_n_o);

  p_no_strobe_in_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n_o && !program_i) |=> !frame_done_o);

  p_program_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    program_i |=> (init_n_o && !cfg_done_o && !frame_done_o));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done_o && !program_i) |=> cfg_done_o);

  p_frame_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    counted |-> (bcnt <= {1'b0, len_q}));

  p_len_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && !program_i) |=> $stable(len_q));

  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_done_o && !init_n_o));

endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker
  import cfg_chk_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  program_i,
  input  logic                  crc_mode_i,
  input  logic                  byte_mode_i,
  input  logic                  bit_valid_i,
  input  logic                  bit_i,
  input  logic                  byte_valid_i,
  input  logic [7:0]            byte_i,
  output logic [FRAME_BITS-1:0] frame_data_o,
  output logic                  frame_done_o,
  output logic [23:0]           length_o,
  output logic                  init_n_o,
  output logic                  cfg_done_o
);
  logic       ser_v, ser_b, src_v, src_b, crc_en;
  logic [3:0] crc_nib;

  cfg_byte_ser u_ser (
    .clk(clk), .rst_n(rst_n),
    .load_i(byte_mode_i && byte_valid_i), .byte_i(byte_i),
    .bit_v_o(ser_v), .bit_o(ser_b)
  );

  assign src_v = byte_mode_i ? ser_v : bit_valid_i;
  assign src_b = byte_mode_i ? ser_b : bit_i;

  cfg_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr_i(program_i),
    .en_i(crc_en), .bit_i(src_b), .chk_nib_o(crc_nib)
  );

  cfg_parser #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_par (
    .clk(clk), .rst_n(rst_n), .program_i(program_i), .crc_mode_i(crc_mode_i),
    .bv_i(src_v), .b_i(src_b), .crc_nib_i(crc_nib), .crc_en_o(crc_en),
    .frame_data_o(frame_data_o), .frame_done_o(frame_done_o),
    .length_o(length_o), .init_n_o(init_n_o), .cfg_done_o(cfg_done_o)
  );

endmodule

// File: tb/cfg_stream_checker_tb.sv
`timescale 1ns/1ps
module cfg_stream_checker_tb_top;
  localparam int N = 8;
  localparam int F = 3;
  localparam int GOOD_LEN = 4 + F * (N + 5) + 8;

  logic clk = 1'b0, rst_n = 1'b0, program_i = 1'b0, crc_mode_i = 1'b0;
  logic byte_mode_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [N-1:0] frame_data_o;
  logic frame_done_o, init_n_o, cfg_done_o;
  logic [23:0] length_o;

  int n_chk = 0, n_bad = 0;
  int sn = 0;
  logic sb [0:511];
  int cap_n = 0;
  logic [N-1:0] cap [0:15];

  always #2 clk = ~clk;

  cfg_stream_checker #(.FRAME_BITS(N), .NUM_FRAMES(F)) dut_i (.*);

  always @(negedge clk) if (frame_done_o && cap_n < 16) begin
    cap[cap_n] = frame_data_o; cap_n = cap_n + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pay_of(input int f);
    return N'((f * 37 + 11) & 8'hFF);
  endfunction

  // bench-side CRC: explicit taps at x^15, x^2, x^0
  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = c << 1;
    if (c[15] != b) begin s[15] = ~s[15]; s[2] = ~s[2]; s[0] = ~s[0]; end
    return s;
  endfunction

  task automatic push(input logic b);
    sb[sn] = b; sn++;
  endtask

  task automatic push_msb(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) push(v[i]);
  endtask

  task automatic build(input int fill, input int lendelta, input bit crcm,
                       input int badsep, input int badstart, input int badchk,
                       input int nfr, input int stup);
    logic [15:0] c;
    logic [3:0]  ck;
    logic [N-1:0] p;
    c = '0; sn = 0;
    for (int i = 0; i < fill; i++) push(1'b1);
    push_msb(4'b0010, 4);
    push_msb(GOOD_LEN + lendelta, 24);
    for (int i = 0; i < 4; i++) push(badsep == i ? 1'b0 : 1'b1);
    for (int f = 0; f < nfr; f++) begin
      push(badstart == f); c = tb_crc(c, badstart == f);
      p = (f < F) ? pay_of(f) : '0;
      for (int i = 0; i < N; i++) begin push(p[i]); c = tb_crc(c, p[i]); end
      ck = crcm ? c[3:0] : 4'b0110;
      if (badchk == f) ck = ck ^ 4'b0001;
      push_msb(ck, 4);
    end
    push_msb(8'b01111111, 8);
    for (int i = 0; i < stup; i++) push(i[0]);
  endtask

  task automatic play_bits();
    byte_mode_i = 1'b0;
    for (int i = 0; i < sn; i++) begin
      @(negedge clk); bit_valid_i = 1'b1; bit_i = sb[i];
    end
    @(negedge clk); bit_valid_i = 1'b0;
  endtask

  task automatic play_bytes();
    while (sn % 8 != 0) push(1'b1);
    byte_mode_i = 1'b1;
    for (int j = 0; j < sn / 8; j++) begin
      @(negedge clk); byte_valid_i = 1'b1;
      for (int k = 0; k < 8; k++) byte_i[k] = sb[8*j + k];
      @(negedge clk); byte_valid_i = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    byte_mode_i = 1'b0;
  endtask

  task automatic do_program();
    @(negedge clk); program_i = 1'b1;
    @(negedge clk); program_i = 1'b0;
    check(init_n_o && !cfg_done_o && !frame_done_o, "R1 program clear", {init_n_o, cfg_done_o}, 2);
    cap_n = 0;
  endtask

  task automatic t_reset();
    check(init_n_o == 1'b1, "R1 reset init_n", init_n_o, 1);
    check(cfg_done_o == 1'b0, "R1 reset done", cfg_done_o, 0);
    check(length_o == 24'd0, "R1 reset length", length_o, 0);
  endtask

  task automatic good_frames(input string tag);
    check(cap_n == F, {tag, " frame count"}, cap_n, F);
    for (int f = 0; f < F; f++)
      check(cap[f] == pay_of(f), {tag, " payload"}, cap[f], pay_of(f));
  endtask

  task automatic t_good_const();
    do_program(); crc_mode_i = 1'b0;
    build(8, 0, 1'b0, -1, -1, -1, F, 4); play_bits();
    check(cfg_done_o && init_n_o, "R6 R10 const stream done", {cfg_done_o, init_n_o}, 3);
    check(length_o == GOOD_LEN, "R3 length", length_o, GOOD_LEN);
    good_frames("R8 const");
  endtask

  task automatic t_good_crc();
    do_program(); crc_mode_i = 1'b1;
    build(8, 0, 1'b1, -1, -1, -1, F, 4); play_bits();
    check(cfg_done_o && init_n_o, "R7 crc stream done", {cfg_done_o, init_n_o}, 3);
    good_frames("R8 crc");
  endtask

  task automatic t_bad_crc_sticky();
    do_program(); crc_mode_i = 1'b1;
    build(8, 0, 1'b1, -1, -1, 1, F, 4); play_bits();
    check(!init_n_o && !cfg_done_o, "R7 bad crc error", {init_n_o, cfg_done_o}, 0);
    check(cap_n == 1, "R7 frames before error", cap_n, 1);
    build(8, 0, 1'b1, -1, -1, -1, F, 4); play_bits();
    check(!init_n_o && !cfg_done_o && cap_n == 1, "R12 input ignored in error", cap_n, 1);
    do_program();
    check(init_n_o, "R1 program clears error", init_n_o, 1);
  endtask

  task automatic t_bad_const();
    do_program(); crc_mode_i = 1'b0;
    build(8, 0, 1'b0, -1, -1, 0, F, 4); play_bits();
    check(!init_n_o && cap_n == 0, "R6 bad constant check", {init_n_o, cap_n[0]}, 0);
  endtask

  task automatic t_fill();
    do_program(); crc_mode_i = 1'b0;
    sn = 0;
    build(12, 0, 1'b0, -1, -1, -1, F, 4); play_bits();
    check(cfg_done_o && length_o == GOOD_LEN, "R2 long fill", length_o, GOOD_LEN);
    do_program();
    build(8, 0, 1'b0, -1, -1, -1, F, 4);
    for (int i = sn - 1; i >= 0; i--) sb[i + 11] = sb[i];
    for (int i = 0; i < 7; i++) sb[i] = 1'b1;
    sb[7] = 0; sb[8] = 0; sb[9] = 1; sb[10] = 0;
    sn = sn + 11; play_bits();
    check(cfg_done_o && length_o == GOOD_LEN, "R2 short fill no lock", length_o, GOOD_LEN);
  endtask

  task automatic t_sep_start();
    do_program(); build(8, 0, 1'b0, 2, -1, -1, F, 4); play_bits();
    check(!init_n_o, "R4 separator error", init_n_o, 0);
    do_program(); build(8, 0, 1'b0, -1, 1, -1, F, 4); play_bits();
    check(!init_n_o && cap_n == 1, "R5 start bit error", cap_n, 1);
  endtask

  task automatic t_post();
    do_program(); crc_mode_i = 1'b0;
    build(8, 0 + (N + 5), 1'b0, -1, -1, -1, F + 1, 4); play_bits();
    check(!init_n_o && !cfg_done_o, "R9 surplus frame error", init_n_o, 0);
    check(cap_n == F, "R9 frames before postamble", cap_n, F);
  endtask

  task automatic t_startup();
    do_program(); crc_mode_i = 1'b0;
    build(8, 0, 1'b0, -1, -1, -1, F, 3); play_bits();
    check(!cfg_done_o && init_n_o, "R10 three start-up bits", cfg_done_o, 0);
    sn = 0; push(1'b0); play_bits();
    check(cfg_done_o, "R10 fourth start-up bit", cfg_done_o, 1);
  endtask

  task automatic t_overrun();
    do_program(); crc_mode_i = 1'b0;
    build(8, -1, 1'b0, -1, -1, -1, F, 4); play_bits();
    check(!init_n_o && !cfg_done_o, "R11 overrun on last postamble bit", init_n_o, 0);
    check(cap_n == F, "R11 frames before overrun", cap_n, F);
  endtask

  task automatic t_bytes();
    do_program(); crc_mode_i = 1'b1;
    build(8, 0, 1'b1, -1, -1, -1, F, 4); play_bytes();
    check(cfg_done_o && init_n_o, "R13 byte mode done", cfg_done_o, 1);
    good_frames("R13 byte");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_const();
    t_good_crc();
    t_bad_crc_sticky();
    t_bad_const();
    t_fill();
    t_sep_start();
    t_post();
    t_startup();
    t_overrun();
    t_bytes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule